// File: doc/BRIEF.md
# Host-Clocked Z80 Bus Cycle Sequencer

This block acts as a Z80-style bus master toward a host system and is clocked directly by the host CLK. An internal client asks for one bus cycle at a time: an opcode fetch, a memory read or write, an I/O read or write, or an interrupt acknowledge. Each request carries an address and, for writes, a data byte. The sequencer then steps through the T-states of that cycle. It drives the address and the active-low strobes, drives the data bus only while it is writing, and samples read data at a fixed falling edge. Read data goes back to the client together with a one-cycle valid flag.

The client also sees three separate one-cycle event pulses in each bus cycle. One marks entry into T1. One marks the point where the address has been stable for a full clock (cycle start). One marks the T-state in which the data is driven or sampled (data phase). The host can take the bus with an active-low bus request. The sequencer honours it only between cycles. While the host holds it, the sequencer asserts bus acknowledge and floats the control strobes, HALT and the data bus. When host reset is released, a reset event pulse is produced.

Top module: `z80_bus_master`

## Requirements
- R1: While rst_n is low, the sequencer is held idle: all strobes are high, d_oe is 0, busack_n is 1, and any cycle in progress is abandoned at once. On the first rising edge after release, evt_reset goes high for exactly one clock.
- R2: An opcode fetch lasts four states. In T1 only m1_n is low. In T2 and T3, m1_n, mreq_n and rd_n are low. In T4 only rfsh_n is low. The fetched byte is returned with rd_valid during T4.
- R3: A memory read asserts mreq_n and rd_n in T2 and T3. A memory write asserts mreq_n in T2 and T3, and wr_n in T3 only. Each takes three states, and iorq_n stays high throughout.
- R4: An I/O read or write asserts iorq_n together with rd_n (read) or wr_n (write) from T2 through T3. IO_WAIT wait states (default 1) are inserted between T2 and T3. mreq_n stays high throughout.
- R5: An interrupt acknowledge keeps m1_n low from T1 through T3. It asserts iorq_n only in the wait states and T3, never asserts rd_n or mreq_n, and returns the byte on the data bus as read data.
- R6: The requested address appears on addr from T1 and is held unchanged until the next accepted request.
- R7: Each cycle raises evt_t1 during T1, evt_start during T2 and evt_data during T3. Each is high for exactly one clock.
- R8: d_oe is 1 only in T2, the wait states and T3 of write cycles, with d_out equal to the request's write data. Read data is taken at the falling clock edge inside T3. rd_valid is high in the clock after T3, with rd_data holding that byte.
- R9: req_ready is 1 only when idle with no bus request. A request is taken when req_valid and req_ready are both 1. The req_kind codes are: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge. Codes 6 and 7 are ignored, and the sequencer stays idle.
- R10: A busreq_n low seen during a cycle takes effect only after the cycle's last state; busreq_n low seen while idle takes effect at the next clock. While granted, busack_n is 0, ctl_oe is 0, d_oe is 0 and no request is taken. The sequencer returns to idle one clock after busreq_n goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Host reset, active low, asynchronous |
| busreq_n | input | 1 | Host bus request, active low |
| req_valid | input | 1 | Client request strobe |
| req_kind | input | 3 | Cycle type code |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Sequencer can accept a request |
| d_in | input | DW | Data bus input |
| d_out | output | DW | Data bus output value |
| d_oe | output | 1 | Data bus output enable |
| addr | output | AW | Address bus |
| mreq_n | output | 1 | Memory request strobe |
| iorq_n | output | 1 | I/O request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| m1_n | output | 1 | Machine cycle one strobe |
| rfsh_n | output | 1 | Refresh strobe |
| halt_n | output | 1 | Halt status (inactive) |
| ctl_oe | output | 1 | Output enable for the strobes and halt_n |
| busack_n | output | 1 | Bus acknowledge, active low |
| evt_t1 | output | 1 | T1 event pulse |
| evt_start | output | 1 | Cycle start event pulse |
| evt_data | output | 1 | Data phase event pulse |
| evt_reset | output | 1 | Reset event pulse |
| rd_data | output | DW | Captured read byte |
| rd_valid | output | 1 | rd_data valid pulse |

## Verification
Each of the six cycle types is run with a distinct address and data byte. This separates the strobe pattern, the state count and the wait-state insertion for each type, and shows which types return data and which drive it. In every read, the data input is flipped after the falling edge in T3, so a capture at any other edge would return the wrong byte. One I/O write has a bus request arriving mid-cycle, which separates grant-at-end-of-cycle from an immediate grant. An idle-time request tests the immediate case. Reserved kind codes, and a reset in the middle of a write, check that nothing starts and that a cycle in progress is dropped.

// File: rtl/z80_bus_master.sv
module z80_bus_master #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int IO_WAIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busreq_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out,
  output logic          d_oe,
  output logic [AW-1:0] addr,
  output logic          mreq_n,
  output logic          iorq_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          m1_n,
  output logic          rfsh_n,
  output logic          halt_n,
  output logic          ctl_oe,
  output logic          busack_n,
  output logic          evt_t1,
  output logic          evt_start,
  output logic          evt_data,
  output logic          evt_reset,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  localparam int WCW = (IO_WAIT > 1) ? $clog2(IO_WAIT + 1) : 1;
  localparam logic [2:0] K_FETCH = 3'd0, K_MRD = 3'd1, K_MWR = 3'd2,
                         K_IORD  = 3'd3, K_IOWR = 3'd4, K_IACK = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3, S_T4, S_GNT} st_t;

  st_t           state;
  logic [2:0]    kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, rdat_q;
  logic [WCW-1:0] wcnt;
  logic          rst_pend, evt_reset_q, rd_valid_q;

  wire go    = (state == S_IDLE) && busreq_n && req_valid && (req_kind <= K_IACK);
  wire is_io = (kind_q == K_IORD) || (kind_q == K_IOWR) || (kind_q == K_IACK);
  wire is_rd = (kind_q == K_FETCH) || (kind_q == K_MRD) || (kind_q == K_IORD) || (kind_q == K_IACK);
  wire is_wr = (kind_q == K_MWR) || (kind_q == K_IOWR);

  wire s1 = state == S_T1;
  wire s2 = state == S_T2;
  wire sw = state == S_TW;
  wire s3 = state == S_T3;
  wire s4 = state == S_T4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      kind_q      <= K_FETCH;
      addr_q      <= '0;
      wdat_q      <= '0;
      wcnt        <= '0;
      rst_pend    <= 1'b1;
      evt_reset_q <= 1'b0;
      rd_valid_q  <= 1'b0;
    end else begin
      evt_reset_q <= rst_pend;
      rst_pend    <= 1'b0;
      rd_valid_q  <= s3 && is_rd;
      case (state)
        S_IDLE: begin
          if (!busreq_n) state <= S_GNT;
          else if (go) begin
            state  <= S_T1;
            kind_q <= req_kind;
            addr_q <= req_addr;
            wdat_q <= req_wdata;
          end
        end
        S_T1: state <= S_T2;
        S_T2: begin
          if (is_io && IO_WAIT > 0) begin
            state <= S_TW;
            wcnt  <= WCW'(IO_WAIT - 1);
          end else state <= S_T3;
        end
        S_TW: begin
          if (wcnt == '0) state <= S_T3;
          else wcnt <= wcnt - 1'b1;
        end
        S_T3: begin
          if (kind_q == K_FETCH) state <= S_T4;
          else if (!busreq_n) state <= S_GNT;
          else state <= S_IDLE;
        end
        S_T4:  state <= busreq_n ? S_IDLE : S_GNT;
        S_GNT: if (busreq_n) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rdat_q <= '0;
    else if (s3 && is_rd) rdat_q <= d_in;
  end

  wire fetch = kind_q == K_FETCH;
  wire iack  = kind_q == K_IACK;

  wire a_m1   = (fetch && (s1 || s2 || s3)) || (iack && (s1 || s2 || sw || s3));
  wire a_mreq = !is_io && (s2 || s3);
  wire a_iorq = ((kind_q == K_IORD || kind_q == K_IOWR) && (s2 || sw || s3)) || (iack && (sw || s3));
  wire a_rd   = ((fetch || kind_q == K_MRD) && (s2 || s3)) || (kind_q == K_IORD && (s2 || sw || s3));
  wire a_wr   = (kind_q == K_MWR && s3) || (kind_q == K_IOWR && (s2 || sw || s3));

  assign mreq_n    = ~a_mreq;
  assign iorq_n    = ~a_iorq;
  assign rd_n      = ~a_rd;
  assign wr_n      = ~a_wr;
  assign m1_n      = ~a_m1;
  assign rfsh_n    = ~s4;
  assign halt_n    = 1'b1;
  assign ctl_oe    = state != S_GNT;
  assign busack_n  = state != S_GNT;
  assign d_oe      = is_wr && (s2 || sw || s3);
  assign d_out     = wdat_q;
  assign addr      = addr_q;
  assign req_ready = (state == S_IDLE) && busreq_n;
  assign evt_t1    = s1;
  assign evt_start = s2;
  assign evt_data  = s3;
  assign evt_reset = evt_reset_q;
  assign rd_data   = rdat_q;
  assign rd_valid  = rd_valid_q;

endmodule

module z80_bus_master_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          d_oe,
  input logic [AW-1:0] addr,
  input logic          mreq_n,
  input logic          iorq_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          m1_n,
  input logic          rfsh_n,
  input logic          ctl_oe,
  input logic          busack_n,
  input logic          evt_t1,
  input logic          evt_start,
  input logic          evt_data,
  input logic          rd_valid
);

  a_r3_mreq_iorq_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mreq_n && !iorq_n));

  a_r8_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r10_grant_floats: assert property (@(posedge clk) disable iff (!rst_n)
    !busack_n |-> (!ctl_oe && !d_oe && !req_ready));

  a_r8_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> (rd_n && (!mreq_n || !iorq_n)));

  a_r7_t1_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    evt_t1 |=> (evt_start && !evt_t1));

  a_r8_valid_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(evt_data));

  a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_start || evt_data) |-> $stable(addr));

  a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mreq_n && iorq_n && m1_n && rfsh_n && !d_oe));

endmodule

bind z80_bus_master z80_bus_master_chk #(.AW(AW)) u_chk (.*);

// File: tb/z80_bus_master_tb.sv
module z80_bus_master_tb;

  logic        clk = 1'b0;
  logic        rst_n, busreq_n, req_valid;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, d_in;
  logic        req_ready, d_oe, mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, halt_n;
  logic        ctl_oe, busack_n, evt_t1, evt_start, evt_data, evt_reset, rd_valid;
  logic [7:0]  d_out, rd_data;
  logic [15:0] addr;

  always #5 clk = ~clk;

  z80_bus_master u_dut (
    .clk(clk), .rst_n(rst_n), .busreq_n(busreq_n), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .m1_n(m1_n), .rfsh_n(rfsh_n), .halt_n(halt_n), .ctl_oe(ctl_oe),
    .busack_n(busack_n), .evt_t1(evt_t1), .evt_start(evt_start),
    .evt_data(evt_data), .evt_reset(evt_reset), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  typedef struct packed {
    logic rdy, m1, mreq, iorq, rd, wr, rfsh, doe, t1, st, dt, rv, bak, coe;
    logic [15:0] a;
    logic [7:0]  wd, rdd;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tg, act, exp);
    end
  endtask

  always begin
    obs_t e, a;
    string t;
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = '{rdy:req_ready, m1:m1_n, mreq:mreq_n, iorq:iorq_n, rd:rd_n, wr:wr_n,
            rfsh:rfsh_n, doe:d_oe, t1:evt_t1, st:evt_start, dt:evt_data,
            rv:rd_valid, bak:busack_n, coe:ctl_oe, a:addr,
            wd:(d_oe ? d_out : 8'h00), rdd:(rd_valid ? rd_data : 8'h00)};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic issue(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                       input logic [7:0] dv, input bit grant, input string tg);
    int n, p3;
    obs_t it;
    bit io, rdk;
    io  = (k == 3) || (k == 4) || (k == 5);
    rdk = (k == 0) || (k == 1) || (k == 3) || (k == 5);
    n   = (k == 0 || io) ? 4 : 3;
    p3  = io ? 4 : 3;
    @(posedge clk);
    #2;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; d_in = dv;
    for (int s = 1; s <= n + 1; s++) begin
      it = '{rdy:1'b0, m1:1'b1, mreq:1'b1, iorq:1'b1, rd:1'b1, wr:1'b1, rfsh:1'b1,
             doe:1'b0, t1:1'b0, st:1'b0, dt:1'b0, rv:1'b0, bak:1'b1, coe:1'b1,
             a:a, wd:8'h00, rdd:8'h00};
      if (s == 1) it.t1 = 1'b1;
      if (s == 2) it.st = 1'b1;
      if (s == p3) it.dt = 1'b1;
      case (k)
        3'd0: begin
          if (s <= 3) it.m1 = 1'b0;
          if (s == 2 || s == 3) begin it.mreq = 1'b0; it.rd = 1'b0; end
          if (s == 4) begin it.rfsh = 1'b0; it.rv = 1'b1; it.rdd = dv; end
        end
        3'd1: if (s == 2 || s == 3) begin it.mreq = 1'b0; it.rd = 1'b0; end
        3'd2: begin
          if (s == 2 || s == 3) begin it.mreq = 1'b0; it.doe = 1'b1; it.wd = wd; end
          if (s == 3) it.wr = 1'b0;
        end
        3'd3: if (s >= 2 && s <= 4) begin it.iorq = 1'b0; it.rd = 1'b0; end
        3'd4: if (s >= 2 && s <= 4) begin it.iorq = 1'b0; it.wr = 1'b0; it.doe = 1'b1; it.wd = wd; end
        default: begin
          if (s <= 4) it.m1 = 1'b0;
          if (s == 3 || s == 4) it.iorq = 1'b0;
        end
      endcase
      if (s == n + 1) begin
        if (grant) begin it.bak = 1'b0; it.coe = 1'b0; end
        else it.rdy = 1'b1;
        if (rdk && k != 0) begin it.rv = 1'b1; it.rdd = dv; end
      end
      exp_q.push_back(it);
      tag_q.push_back({tg, " R6 R7 R8"});
    end
    @(posedge clk);
    #2;
    req_valid = 1'b0;
    for (int c = 2; c <= n; c++) begin
      @(posedge clk);
      if (c == 2 && grant) begin #2; busreq_n = 1'b0; end
      if (c == p3 && rdk) begin #7; d_in = ~dv; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; busreq_n = 1'b1; req_valid = 1'b0; req_kind = 3'd0;
    req_addr = 16'h0000; req_wdata = 8'h00; d_in = 8'h00;

    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 strobes", {26'd0, mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n}, 32'h3f);
    chk("R1 d_oe/busack/evt_reset", {29'd0, d_oe, busack_n, evt_reset}, 32'b010);
    @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk);
    #1 chk("R1 evt_reset pulse", {30'd0, evt_reset, req_ready}, 32'b11);
    @(posedge clk);
    #1 chk("R1 evt_reset ends", {31'd0, evt_reset}, 32'd0);

    issue(3'd0, 16'h1234, 8'h00, 8'hA5, 1'b0, "R2");
    issue(3'd1, 16'hBEEF, 8'h00, 8'h3C, 1'b0, "R3");
    issue(3'd2, 16'h8001, 8'h5A, 8'h00, 1'b0, "R3");
    issue(3'd3, 16'h00FE, 8'h00, 8'hC3, 1'b0, "R4");
    issue(3'd4, 16'h0042, 8'h81, 8'h00, 1'b0, "R4");
    issue(3'd5, 16'hFFFF, 8'h00, 8'hE7, 1'b0, "R5");
    issue(3'd0, 16'h0000, 8'h00, 8'h18, 1'b0, "R2");

    // R9 reserved codes ignored
    @(posedge clk);
    #2 req_valid = 1'b1; req_kind = 3'd6; req_addr = 16'h5555;
    @(posedge clk);
    #1 chk("R9 code 6", {29'd0, req_ready, evt_t1, mreq_n}, 32'b101);
    #1 req_kind = 3'd7;
    @(posedge clk);
    #1 chk("R9 code 7", {13'd0, req_ready, evt_t1, iorq_n, addr}, {13'd0, 3'b101, 16'h0000});
    #1 req_valid = 1'b0;

    // R10 request during a cycle honoured at its end
    issue(3'd4, 16'h1357, 8'h66, 8'h00, 1'b1, "R10");
    @(posedge clk);
    #2 req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h2468;
    repeat (3) @(posedge clk);
    #1 chk("R10 held grant", {28'd0, busack_n, req_ready, evt_t1, ctl_oe}, 32'b0000);
    #1 req_valid = 1'b0; busreq_n = 1'b1;
    @(posedge clk);
    #1 chk("R10 release", {29'd0, busack_n, req_ready, ctl_oe}, 32'b111);

    // R10 request while idle
    @(posedge clk);
    #2 busreq_n = 1'b0;
    @(posedge clk);
    #1 chk("R10 idle grant", {29'd0, busack_n, ctl_oe, d_oe}, 32'b000);
    #1 busreq_n = 1'b1;
    @(posedge clk);
    #1 chk("R10 idle release", {30'd0, busack_n, req_ready}, 32'b11);

    // R1 reset in the middle of a write
    @(posedge clk);
    #2 req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h4444; req_wdata = 8'h99;
    @(posedge clk);
    #2 req_valid = 1'b0;
    @(posedge clk);
    #1 chk("R8 write drive", {23'd0, d_oe, d_out}, {23'd0, 1'b1, 8'h99});
    #1 rst_n = 1'b0;
    #1 chk("R1 abort", {28'd0, d_oe, mreq_n, wr_n, busack_n}, 32'b0111);
    @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk);
    #1 chk("R1 reset event again", {29'd0, evt_reset, req_ready, mreq_n}, 32'b111);
    @(posedge clk);
    #1 chk("R1 single pulse", {30'd0, evt_reset, evt_t1}, 32'b00);

    repeat (3) @(posedge clk);
    #3 chk("R2 scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule